// File: doc/BRIEF.md
# HDLC Receive Frame Check Sequence Checker

This block sits behind an HDLC receiver that has already removed flags and stuffed zero bits. It takes the frame one byte per cycle, with a start-of-frame mark on the first byte and a separate end-of-frame strobe when the closing flag is seen. It computes a CRC-16/CCITT over each frame and writes the frame to a receive FIFO write port. After the last byte of each frame it adds one status byte. The last two bytes of every frame are taken as the received frame check sequence (FCS).

A two-slot delay line holds back the newest two bytes. A byte leaves for the FIFO only once two later bytes have arrived, so it cannot be part of the FCS. When the closing flag arrives, a configuration input decides what happens to the held pair. It is either dropped, or written to the FIFO just ahead of the status byte. The CRC is checked in both cases. The status byte reports a bad CRC and a short frame.

After an end-of-frame strobe the source keeps `in_valid` and `in_eof` low for three cycles while the block drains. Input that arrives while it drains is ignored.

Top module: `hdlc_rx_fcs_check`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `wr_en` is low.
- R2: A data byte is written to the FIFO one cycle after the byte that follows it by two positions is accepted. Bytes are written in arrival order, with `wr_is_status` low. The two bytes held when the closing flag arrives are never written as data.
- R3: With `cfg_keep_fcs` low, the status byte is written in the cycle after the end-of-frame strobe, with `wr_is_status` high. The FIFO is idle in the cycle after that.
- R4: With `cfg_keep_fcs` high, the two held FCS bytes are written in arrival order in the two cycles after the end-of-frame strobe, with `wr_is_status` low. The status byte follows in the next cycle.
- R5: A frame whose CRC-16/CCITT residue equals 0xF0B8 has status bit 5 clear. The CRC uses the reflected polynomial x^16+x^12+x^5+1, preset 0xFFFF, least significant bit first, over all bytes including the FCS. The FCS is the complement of the data CRC, low byte first.
- R6: A frame with any other residue has status bit 5 set. This holds whether or not the FCS bytes are forwarded.
- R7: Status bit 4 is set when the frame has fewer than 4 bytes including the FCS. It is clear at exactly 4 bytes or more.
- R8: A frame that ends with fewer than two bytes has both status bits 4 and 5 set. With `cfg_keep_fcs` high, its single held byte is forwarded before the status byte.
- R9: Status bits 7, 6 and 3 to 0 are always zero. `wr_is_status` is high only on status bytes.
- R10: A start-of-frame mark inside an open frame restarts the frame. Bytes still held from the abandoned frame are never written, and no status byte is written for the abandoned frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_keep_fcs | input | 1 | Forward the received FCS bytes to the FIFO |
| in_valid | input | 1 | Received byte is valid this cycle |
| in_sof | input | 1 | Qualifies the valid byte as the first byte of a frame |
| in_data | input | 8 | Received byte |
| in_eof | input | 1 | Closing flag seen; carries no byte |
| wr_en | output | 1 | FIFO write strobe |
| wr_data | output | 8 | FIFO write byte |
| wr_is_status | output | 1 | The current write is the frame status byte |

## Verification
Every FIFO write is registered, so a data byte appears exactly one cycle after the edge that accepts the second byte behind it. The first write after the end-of-frame strobe is visible one cycle after that strobe. Forwarded FCS bytes take the following cycles, and the status byte comes one cycle after the last of them. Each scenario task drives inputs on the falling edge and checks `wr_en`, `wr_data` and `wr_is_status` on the next falling edge. It predicts exactly which write, or which idle cycle, that edge must show, so a byte that is early, late, missing or out of order is flagged at the cycle where it goes wrong.

// File: rtl/hdlc_fcs_pkg.sv
package hdlc_fcs_pkg;

    localparam int          BYTE_W      = 8;
    localparam int          FCS_BYTES   = 2;
    localparam logic [15:0] FCS_PRESET  = 16'hFFFF;
    localparam logic [15:0] FCS_POLY    = 16'h8408;
    localparam logic [15:0] FCS_RESIDUE = 16'hF0B8;
    localparam int          ST_BAD_FCS  = 5;
    localparam int          ST_SHORT    = 4;

    typedef enum logic [1:0] {
        PH_RUN,
        PH_FCS,
        PH_STAT
    } phase_t;

    typedef struct packed {
        logic              valid;
        logic              is_status;
        logic [BYTE_W-1:0] data;
    } fifo_wr_t;

    function automatic logic [15:0] fcs_next(input logic [15:0] c, input logic [BYTE_W-1:0] b);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < BYTE_W; i++) begin
            if (r[0] ^ b[i]) r = (r >> 1) ^ FCS_POLY;
            else             r = r >> 1;
        end
        return r;
    endfunction

    function automatic logic [BYTE_W-1:0] status_byte(input logic bad, input logic short_f);
        logic [BYTE_W-1:0] s;
        s = '0;
        s[ST_BAD_FCS] = bad;
        s[ST_SHORT]   = short_f;
        return s;
    endfunction

endpackage

// File: rtl/hdlc_fcs_hold.sv
module hdlc_fcs_hold #(
    parameter int W     = 8,
    parameter int DEPTH = 2,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] cnt,
    output logic          full
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [W-1:0] slot [DEPTH];

    assign head = slot[0];
    assign full = (cnt == FULL_CNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= push ? CW'(1) : '0;
            if (push) slot[0] <= push_data;
        end else if (push) begin
            if (full) begin
                for (int k = 0; k < DEPTH - 1; k++) slot[k] <= slot[k+1];
                slot[DEPTH-1] <= push_data;
            end else begin
                slot[cnt[IW-1:0]] <= push_data;
                cnt <= cnt + CW'(1);
            end
        end else if (pop && cnt != '0) begin
            for (int k = 0; k < DEPTH - 1; k++) slot[k] <= slot[k+1];
            cnt <= cnt - CW'(1);
        end
    end

    // R2: the delay line never holds more than its depth
    a_r2_depth_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL_CNT);

    // R2: a spill advances the next older byte to the head
    a_r2_spill_order: assert property (@(posedge clk) disable iff (rst)
        push && full && !clear |=> head == $past(slot[1]));

endmodule

// File: rtl/hdlc_fcs_acc.sv
module hdlc_fcs_acc
    import hdlc_fcs_pkg::*;
#(
    parameter int LEN_MIN = 4,
    localparam int LW     = $clog2(LEN_MIN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              start,
    input  logic [BYTE_W-1:0] data,
    output logic              fcs_ok,
    output logic              too_short,
    output logic              too_few
);

    localparam logic [LW-1:0] LEN_CAP = LW'(LEN_MIN);
    localparam logic [LW-1:0] LEN_FCS = LW'(FCS_BYTES);

    logic [15:0]   crc_q;
    logic [LW-1:0] len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= FCS_PRESET;
            len_q <= '0;
        end else if (take) begin
            crc_q <= fcs_next(start ? FCS_PRESET : crc_q, data);
            if (start)                len_q <= LW'(1);
            else if (len_q < LEN_CAP) len_q <= len_q + LW'(1);
        end
    end

    assign fcs_ok    = (crc_q == FCS_RESIDUE);
    assign too_short = (len_q < LEN_CAP);
    assign too_few   = (len_q < LEN_FCS);

    // R7: the length count saturates at the short-frame limit
    a_r7_len_cap: assert property (@(posedge clk) disable iff (rst)
        len_q <= LEN_CAP);

    // R10: a start mark restarts the length at one byte
    a_r10_start_len: assert property (@(posedge clk) disable iff (rst)
        take && start |=> len_q == LW'(1));

endmodule

// File: rtl/hdlc_rx_fcs_check.sv
module hdlc_rx_fcs_check
    import hdlc_fcs_pkg::*;
#(
    parameter int LEN_MIN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_keep_fcs,
    input  logic       in_valid,
    input  logic       in_sof,
    input  logic [7:0] in_data,
    input  logic       in_eof,
    output logic       wr_en,
    output logic [7:0] wr_data,
    output logic       wr_is_status
);

    localparam int CW = $clog2(FCS_BYTES + 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(FCS_BYTES);

    phase_t      phase_q;
    logic        open_q;
    fifo_wr_t    wr_q;
    logic [7:0]  st_q;

    logic        byte_take, sof_take, eof_take;
    logic        spill, keep_path, hold_clear, hold_pop;
    logic [7:0]  hold_head;
    logic [CW-1:0] hold_cnt;
    logic        hold_full;
    logic        fcs_ok, too_short, too_few;
    logic [7:0]  st_now;

    assign byte_take = (phase_q == PH_RUN) && in_valid && !in_eof && (in_sof || open_q);
    assign sof_take  = byte_take && in_sof;
    assign eof_take  = (phase_q == PH_RUN) && in_eof && open_q;
    assign spill     = byte_take && !in_sof && hold_full;
    assign keep_path = eof_take && cfg_keep_fcs && (hold_cnt != '0);
    assign hold_pop  = keep_path || (phase_q == PH_FCS);
    assign hold_clear = sof_take || (eof_take && !keep_path) || (phase_q == PH_STAT);
    assign st_now    = status_byte(!fcs_ok || too_few, too_short);

    hdlc_fcs_hold #(.W(BYTE_W), .DEPTH(FCS_BYTES)) hold_i (
        .clk       (clk),
        .rst       (rst),
        .clear     (hold_clear),
        .push      (byte_take),
        .push_data (in_data),
        .pop       (hold_pop),
        .head      (hold_head),
        .cnt       (hold_cnt),
        .full      (hold_full)
    );

    hdlc_fcs_acc #(.LEN_MIN(LEN_MIN)) acc_i (
        .clk       (clk),
        .rst       (rst),
        .take      (byte_take),
        .start     (in_sof),
        .data      (in_data),
        .fcs_ok    (fcs_ok),
        .too_short (too_short),
        .too_few   (too_few)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_RUN;
            open_q  <= 1'b0;
            wr_q    <= '0;
            st_q    <= '0;
        end else begin
            wr_q <= '0;
            if (sof_take) open_q <= 1'b1;
            unique case (phase_q)
                PH_RUN: begin
                    if (spill) begin
                        wr_q <= '{valid: 1'b1, is_status: 1'b0, data: hold_head};
                    end else if (eof_take) begin
                        open_q <= 1'b0;
                        st_q   <= st_now;
                        if (keep_path) begin
                            wr_q    <= '{valid: 1'b1, is_status: 1'b0, data: hold_head};
                            phase_q <= (hold_cnt == CNT_FULL) ? PH_FCS : PH_STAT;
                        end else begin
                            wr_q <= '{valid: 1'b1, is_status: 1'b1, data: st_now};
                        end
                    end
                end
                PH_FCS: begin
                    wr_q    <= '{valid: 1'b1, is_status: 1'b0, data: hold_head};
                    phase_q <= PH_STAT;
                end
                PH_STAT: begin
                    wr_q    <= '{valid: 1'b1, is_status: 1'b1, data: st_q};
                    phase_q <= PH_RUN;
                end
                default: phase_q <= PH_RUN;
            endcase
        end
    end

    assign wr_en        = wr_q.valid;
    assign wr_data      = wr_q.data;
    assign wr_is_status = wr_q.is_status;

    // R3: without forwarding, the status byte is the next write after the flag
    a_r3_status_next: assert property (@(posedge clk) disable iff (rst)
        eof_take && !cfg_keep_fcs |=> wr_en && wr_is_status);

    // R4: a forwarded pair is two plain writes followed by the status byte
    a_r4_fcs_then_status: assert property (@(posedge clk) disable iff (rst)
        eof_take && cfg_keep_fcs && hold_cnt == CNT_FULL |=>
        (wr_en && !wr_is_status) ##1 (wr_en && !wr_is_status) ##1 (wr_en && wr_is_status));

    // R8: a frame with under two bytes reports both error bits
    a_r8_tiny_fails: assert property (@(posedge clk) disable iff (rst)
        eof_take && !cfg_keep_fcs && too_few |=> wr_data[ST_BAD_FCS] && wr_data[ST_SHORT]);

    // R9: unused status bits stay zero
    a_r9_zero_bits: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_is_status |-> (wr_data & 8'hCF) == 8'h00);

    // R9: the status marker never appears without a write
    a_r9_marker_with_write: assert property (@(posedge clk) disable iff (rst)
        wr_is_status |-> wr_en);

    // R1: no write in the cycle following reset release
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> !wr_en);

endmodule

// File: tb/hdlc_rx_fcs_check_tb_top.sv
module hdlc_rx_fcs_check_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_keep_fcs;
    logic       in_valid;
    logic       in_sof;
    logic [7:0] in_data;
    logic       in_eof;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       wr_is_status;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [7:0] fb [0:31];
    int         flen;

    always #10 clk = ~clk;

    hdlc_rx_fcs_check dut_i (
        .clk          (clk),
        .rst          (rst),
        .cfg_keep_fcs (cfg_keep_fcs),
        .in_valid     (in_valid),
        .in_sof       (in_sof),
        .in_data      (in_data),
        .in_eof       (in_eof),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .wr_is_status (wr_is_status)
    );

    task automatic chk(input bit ok, input string req, input logic [9:0] act, input logic [9:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual={en,st,data}=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] ref_crc(input int n);
        logic [15:0] r = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < 8; k++) begin
                logic fbk = r[0] ^ fb[i][k];
                r = {1'b0, r[15:1]};
                if (fbk) r = r ^ 16'h8408;
            end
        end
        return r;
    endfunction

    task automatic make_frame(input int n_data, input logic [7:0] seed, input bit corrupt);
        logic [15:0] c;
        for (int i = 0; i < n_data; i++) fb[i] = seed + 8'(i * 37);
        c = ~ref_crc(n_data);
        fb[n_data]     = c[7:0];
        fb[n_data + 1] = c[15:8];
        flen = n_data + 2;
        if (corrupt) fb[0] = fb[0] ^ 8'h04;
    endtask

    // Drives one frame from a falling edge and checks every write cycle by cycle.
    task automatic send_frame(input int n, input bit keep, input logic [7:0] exp_st, input string req);
        int nf;
        cfg_keep_fcs = keep;
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1;
            in_sof   = (i == 0);
            in_data  = fb[i];
            @(negedge clk);
            if (i >= 2)
                chk(wr_en && !wr_is_status && wr_data == fb[i-2], "R2",
                    {wr_en, wr_is_status, wr_data}, {2'b10, fb[i-2]});
            else
                chk(!wr_en, "R2", {wr_en, wr_is_status, wr_data}, 10'h000);
        end
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_eof   = 1'b1;
        @(negedge clk);
        in_eof = 1'b0;
        nf = keep ? ((n < 2) ? n : 2) : 0;
        for (int j = 0; j < nf; j++) begin
            chk(wr_en && !wr_is_status && wr_data == fb[n-nf+j], (n < 2) ? "R8" : "R4",
                {wr_en, wr_is_status, wr_data}, {2'b10, fb[n-nf+j]});
            @(negedge clk);
        end
        chk(wr_en && wr_is_status && wr_data == exp_st, req,
            {wr_en, wr_is_status, wr_data}, {2'b11, exp_st});
        @(negedge clk);
        chk(!wr_en, "R3", {wr_en, wr_is_status, wr_data}, 10'h000);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        cfg_keep_fcs = 1'b0;
        in_valid = 1'b0;
        in_sof = 1'b0;
        in_data = 8'h00;
        in_eof = 1'b0;
        repeat (3) @(negedge clk);
        chk(!wr_en, "R1", {wr_en, wr_is_status, wr_data}, 10'h000);
        rst = 1'b0;
        @(negedge clk);
        chk(!wr_en, "R1", {wr_en, wr_is_status, wr_data}, 10'h000);
    endtask

    task automatic t_good_drop();
        make_frame(6, 8'h11, 1'b0);
        send_frame(flen, 1'b0, 8'h00, "R5");
        make_frame(12, 8'h7E, 1'b0);
        send_frame(flen, 1'b0, 8'h00, "R3");
    endtask

    task automatic t_bad_drop();
        make_frame(5, 8'hC3, 1'b1);
        send_frame(flen, 1'b0, 8'h20, "R6");
    endtask

    task automatic t_good_keep();
        make_frame(4, 8'h5A, 1'b0);
        send_frame(flen, 1'b1, 8'h00, "R4");
    endtask

    task automatic t_bad_keep();
        make_frame(7, 8'h09, 1'b1);
        send_frame(flen, 1'b1, 8'h20, "R6");
    endtask

    task automatic t_lengths();
        make_frame(2, 8'h33, 1'b0);
        send_frame(flen, 1'b0, 8'h00, "R7");
        make_frame(1, 8'h44, 1'b0);
        send_frame(flen, 1'b0, 8'h10, "R7");
        make_frame(0, 8'h00, 1'b0);
        send_frame(flen, 1'b1, 8'h10, "R7");
    endtask

    task automatic t_tiny();
        fb[0] = 8'hB5;
        send_frame(1, 1'b0, 8'h30, "R8");
        fb[0] = 8'h6C;
        send_frame(1, 1'b1, 8'h30, "R8");
    endtask

    task automatic t_restart();
        cfg_keep_fcs = 1'b0;
        for (int i = 0; i < 3; i++) begin
            in_valid = 1'b1;
            in_sof   = (i == 0);
            in_data  = 8'hA1 + 8'(i);
            @(negedge clk);
        end
        chk(wr_en && !wr_is_status && wr_data == 8'hA1, "R10",
            {wr_en, wr_is_status, wr_data}, {2'b10, 8'hA1});
        make_frame(5, 8'h2D, 1'b0);
        send_frame(flen, 1'b0, 8'h00, "R10");
    endtask

    initial begin
        t_reset();
        t_good_drop();
        t_bad_drop();
        t_good_keep();
        t_bad_keep();
        t_lengths();
        t_tiny();
        t_restart();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule